// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. It takes one missing virtual address at a time. It fetches the first-level entry, which is either a 2 MB page descriptor or a pointer to a second-level table. For a pointer it then fetches the two-word second-level entry. The walk ends in exactly one of two ways: a refill record (a 28-bit 4 KB page number, ten flag bits and a big-page marker) or a fault code with the faulting virtual address.

When the access needs a bookkeeping bit that the entry does not yet carry, the walker sets it in memory. These bits are the local-access bit, the remote-access bit and the dirty bit. The flag word is always fetched with a load-linked read. A store-conditional then writes the merged word back. If the store-conditional is refused, the walker repeats the load-linked read, evaluates the fresh word and decides again. The memory side has one request in flight at a time. A request stays asserted until a one-cycle acknowledge arrives.

Top module: `ptw_walker`

## Requirements
- R1: After reset and whenever the walker is idle, `busy`, `mem_req` and `done` are low.
- R2: An accepted miss first issues a load-linked request (`mem_op`=1) at address `root_base` + VA[31:21]×4. The request, its address and its op stay stable until `mem_ack`.
- R3: A first-level word with V (bit 31) set and T (bit 30) set is a table pointer. The walker load-links the word at ({word[27:0], 12'h000} + VA[20:12]×8). After any flag update it plain-reads (`mem_op`=0) the next word at that address + 4. The refill then carries `ref_ppn` = that word's bits [27:0] and `ref_big`=0.
- R4: A first-level word with V=1 and T=0 is a 2 MB page. The refill carries `ref_ppn` = {word[18:0], VA[20:12]} and `ref_big`=1.
- R5: An entry with V=0 ends the walk with `fault`=1 and `fault_va` = the missing address. The code is `fault_code`=1 at the first level and 2 at the second level. No store-conditional is issued.
- R6: A miss from a local requester (`miss_remote`=0) sets L (bit 29) if it is clear. A miss from a remote requester sets R (bit 28) if it is clear.
- R7: A write miss (`miss_write`=1) sets D (bit 22) if it is clear.
- R8: A flag update is a store-conditional (`mem_op`=2) of the load-linked word ORed with the missing bits. No store-conditional is issued when no bit is missing.
- R9: A refused store-conditional (`mem_sc_ok`=0) is followed by a new load-linked read of the same address, and the decision is remade from the new word.
- R10: `busy` rises on acceptance and falls after the one-cycle `done` pulse. `miss_valid` is ignored while busy.
- R11: `ref_flags` holds bits [31:22] of the entry's flag word as it stands after any update. The order is V,T,L,R,C,W,X,U,G,D from bit 31 down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 40 | First-level table base address, sampled on acceptance |
| miss_valid | input | 1 | A translation miss is presented |
| miss_va | input | 32 | Missing virtual address |
| miss_write | input | 1 | The missing access is a write |
| miss_remote | input | 1 | The missing access comes from a remote requester |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request valid |
| mem_op | output | 2 | 0 plain read, 1 load-linked, 2 store-conditional |
| mem_addr | output | 40 | Byte address of the request |
| mem_wdata | output | 32 | Store-conditional data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_sc_ok | input | 1 | Store-conditional succeeded, valid with `mem_ack` |
| done | output | 1 | One-cycle pulse: refill or fault is presented |
| fault | output | 1 | The finished walk faulted |
| fault_code | output | 2 | 1 first-level invalid, 2 second-level invalid |
| fault_va | output | 32 | Virtual address of the finished walk |
| ref_ppn | output | 28 | Refill 4 KB page number |
| ref_flags | output | 10 | Refill flag bits |
| ref_big | output | 1 | Refill comes from a 2 MB page |

## Verification
Each memory request rises in the cycle after the clock edge that acknowledged the previous request. The bench memory acknowledges at the following falling edge. `done` and the refill or fault fields are registered, so they appear in the cycle right after the edge that consumed the final acknowledge. The bench waits for `done` at falling edges and reads all result fields in that same half-cycle. It reads memory contents and its own log of requested addresses and ops only after `done`, and idle behaviour only after `busy` has dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 40;
  localparam int DW       = 32;
  localparam int PG_SH    = 12;
  localparam int BIG_SH   = 21;
  localparam int PPN_W    = 28;
  localparam int PPN1_W   = 19;
  localparam int FLAG_W   = 10;
  localparam int L1_IDX_W = VA_W - BIG_SH;
  localparam int L2_IDX_W = BIG_SH - PG_SH;
  localparam int L1_ESZ_SH = 2;
  localparam int L2_ESZ_SH = 3;

  localparam int B_V = 31;
  localparam int B_T = 30;
  localparam int B_L = 29;
  localparam int B_R = 28;
  localparam int B_D = 22;

  typedef enum logic [1:0] {OP_RD = 2'd0, OP_LL = 2'd1, OP_SC = 2'd2} mem_op_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_L1 = 2'd1, FLT_L2 = 2'd2} fault_e;

  function automatic logic [PA_W-1:0] l1_entry_addr(input logic [PA_W-1:0] root,
                                                     input logic [VA_W-1:0] va);
    logic [PA_W-1:0] off;
    off = PA_W'(va[VA_W-1:BIG_SH]) << L1_ESZ_SH;
    return root + off;
  endfunction

  function automatic logic [PA_W-1:0] l2_entry_addr(input logic [PPN_W-1:0] base,
                                                     input logic [VA_W-1:0] va);
    logic [PA_W-1:0] off;
    off = PA_W'(va[BIG_SH-1:PG_SH]) << L2_ESZ_SH;
    return {base, {PG_SH{1'b0}}} + off;
  endfunction

  function automatic logic [DW-1:0] missing_bits(input logic [DW-1:0] word,
                                                 input logic remote, input logic write);
    logic [DW-1:0] m;
    m = '0;
    if (!remote && !word[B_L]) m[B_L] = 1'b1;
    if (remote && !word[B_R])  m[B_R] = 1'b1;
    if (write && !word[B_D])   m[B_D] = 1'b1;
    return m;
  endfunction

  function automatic logic [PPN_W-1:0] big_ppn(input logic [DW-1:0] word,
                                               input logic [VA_W-1:0] va);
    return {word[PPN1_W-1:0], va[BIG_SH-1:PG_SH]};
  endfunction

  function automatic logic [FLAG_W-1:0] flags_of(input logic [DW-1:0] word);
    return word[DW-1 -: FLAG_W];
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PA_W-1:0]  root,
  input  logic [VA_W-1:0]  va,
  input  logic [PPN_W-1:0] table_base,
  input  logic             second_word,
  output logic [PA_W-1:0]  l1_addr,
  output logic [PA_W-1:0]  l2_addr
);
  localparam logic [PA_W-1:0] WORD_BYTES = PA_W'(DW / 8);

  always_comb begin
    l1_addr = l1_entry_addr(root, va);
    l2_addr = l2_entry_addr(table_base, va) + (second_word ? WORD_BYTES : '0);
  end
endmodule

// File: rtl/ptw_flag_merge.sv
module ptw_flag_merge
  import ptw_pkg::*;
(
  input  logic [DW-1:0] word,
  input  logic          remote,
  input  logic          write,
  output logic [DW-1:0] merged,
  output logic          need_update
);
  logic [DW-1:0] set_mask;

  always_comb begin
    set_mask    = missing_bits(word, remote, write);
    merged      = word | set_mask;
    need_update = |set_mask;
  end

  always_comb begin
    a_r6_access_bit_present: assert (merged[remote ? B_R : B_L]);
    a_r7_dirty_on_write: assert (!write || merged[B_D]);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              miss_valid,
  input  logic [VA_W-1:0]   miss_va,
  input  logic              miss_write,
  input  logic              miss_remote,
  output logic              busy,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_sc_ok,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [VA_W-1:0]   fault_va,
  output logic [PPN_W-1:0]  ref_ppn,
  output logic [FLAG_W-1:0] ref_flags,
  output logic              ref_big
);
  typedef enum logic [2:0] {
    S_IDLE, S_L1_LL, S_L1_SC, S_L2_LL, S_L2_SC, S_L2_PPN, S_FIN
  } st_e;

  st_e               st;
  logic [PA_W-1:0]   root_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, rem_q;
  logic [PPN_W-1:0]  tbase_q;
  logic [DW-1:0]     wdata_q;
  logic [FLAG_W-1:0] flags_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              big_q, fault_q;
  fault_e            fcode_q;

  logic [PA_W-1:0] l1_addr, l2_addr;
  logic [DW-1:0]   merged;
  logic            need_update;
  logic            accept;
  logic            ack_valid_entry;
  logic            sc_refused;

  ptw_addr_gen u_addr (
    .root(root_q), .va(va_q), .table_base(tbase_q),
    .second_word(st == S_L2_PPN),
    .l1_addr(l1_addr), .l2_addr(l2_addr)
  );

  ptw_flag_merge u_merge (
    .word(mem_rdata), .remote(rem_q), .write(wr_q),
    .merged(merged), .need_update(need_update)
  );

  assign accept          = (st == S_IDLE) && miss_valid;
  assign ack_valid_entry = mem_ack && mem_rdata[B_V];
  assign sc_refused      = mem_ack && !mem_sc_ok;

  always_comb begin
    mem_req   = 1'b0;
    mem_op    = OP_RD;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_L1_LL:  begin mem_req = 1'b1; mem_op = OP_LL; mem_addr = l1_addr; end
      S_L1_SC:  begin mem_req = 1'b1; mem_op = OP_SC; mem_addr = l1_addr; mem_wdata = wdata_q; end
      S_L2_LL:  begin mem_req = 1'b1; mem_op = OP_LL; mem_addr = l2_addr; end
      S_L2_SC:  begin mem_req = 1'b1; mem_op = OP_SC; mem_addr = l2_addr; mem_wdata = wdata_q; end
      S_L2_PPN: begin mem_req = 1'b1; mem_op = OP_RD; mem_addr = l2_addr; end
      default: ;
    endcase
  end

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign fault      = fault_q;
  assign fault_code = fcode_q;
  assign fault_va   = va_q;
  assign ref_ppn    = ppn_q;
  assign ref_flags  = flags_q;
  assign ref_big    = big_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      root_q  <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      rem_q   <= 1'b0;
      tbase_q <= '0;
      wdata_q <= '0;
      flags_q <= '0;
      ppn_q   <= '0;
      big_q   <= 1'b0;
      fault_q <= 1'b0;
      fcode_q <= FLT_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st      <= S_L1_LL;
          root_q  <= root_base;
          va_q    <= miss_va;
          wr_q    <= miss_write;
          rem_q   <= miss_remote;
          fault_q <= 1'b0;
          fcode_q <= FLT_NONE;
        end
        S_L1_LL: if (mem_ack) begin
          if (!ack_valid_entry) begin
            fault_q <= 1'b1;
            fcode_q <= FLT_L1;
            st      <= S_FIN;
          end else if (mem_rdata[B_T]) begin
            tbase_q <= mem_rdata[PPN_W-1:0];
            st      <= S_L2_LL;
          end else if (need_update) begin
            wdata_q <= merged;
            st      <= S_L1_SC;
          end else begin
            flags_q <= flags_of(mem_rdata);
            ppn_q   <= big_ppn(mem_rdata, va_q);
            big_q   <= 1'b1;
            st      <= S_FIN;
          end
        end
        S_L1_SC: if (mem_ack) begin
          if (sc_refused) st <= S_L1_LL;
          else begin
            flags_q <= flags_of(wdata_q);
            ppn_q   <= big_ppn(wdata_q, va_q);
            big_q   <= 1'b1;
            st      <= S_FIN;
          end
        end
        S_L2_LL: if (mem_ack) begin
          if (!ack_valid_entry) begin
            fault_q <= 1'b1;
            fcode_q <= FLT_L2;
            st      <= S_FIN;
          end else if (need_update) begin
            wdata_q <= merged;
            st      <= S_L2_SC;
          end else begin
            flags_q <= flags_of(mem_rdata);
            st      <= S_L2_PPN;
          end
        end
        S_L2_SC: if (mem_ack) begin
          if (sc_refused) st <= S_L2_LL;
          else begin
            flags_q <= flags_of(wdata_q);
            st      <= S_L2_PPN;
          end
        end
        S_L2_PPN: if (mem_ack) begin
          ppn_q <= mem_rdata[PPN_W-1:0];
          big_q <= 1'b0;
          st    <= S_FIN;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_op)));

  a_r5_fault_coded: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code != FLT_NONE));

  a_r9_retry_same_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && mem_op == OP_SC && !mem_sc_ok)
      |=> (mem_req && mem_op == OP_LL && mem_addr == $past(mem_addr)));

  a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && miss_valid) |=> (busy && mem_req && mem_op == OP_LL));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  import ptw_pkg::*;

  localparam logic [39:0] ROOT = 40'h00_0010_0000;

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        rem;
    logic [31:0] l1;
    logic [31:0] l2a;
    logic [31:0] l2b;
    logic [1:0]  efc;
    logic [9:0]  eflg;
    logic [3:0]  esc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0060_3000, 1'b0, 1'b0, 32'hA801_2345, 32'h0, 32'h0,          2'd0, 10'h2A0, 4'd0},
    '{32'h0120_0000, 1'b1, 1'b0, 32'h8400_0007, 32'h0, 32'h0,          2'd0, 10'h291, 4'd1},
    '{32'h8040_5000, 1'b0, 1'b1, 32'hC000_0123, 32'h8B00_0000, 32'hF000_ABCD, 2'd0, 10'h26C, 4'd1},
    '{32'hFFFF_F000, 1'b1, 1'b0, 32'hC000_0456, 32'hA440_0000, 32'h0ABC_DEF1, 2'd0, 10'h291, 4'd0},
    '{32'h0000_0000, 1'b0, 1'b0, 32'h4000_0123, 32'h0, 32'h0,          2'd1, 10'h000, 4'd0},
    '{32'h1234_5678, 1'b0, 1'b0, 32'hC000_0200, 32'h2000_0000, 32'h0,  2'd2, 10'h000, 4'd0},
    '{32'h7FE0_1000, 1'b1, 1'b1, 32'h9087_FFFF, 32'h0, 32'h0,          2'd0, 10'h243, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_va = '0;
  logic        miss_write = 1'b0, miss_remote = 1'b0;
  logic        busy, mem_req, done, fault, ref_big;
  logic [1:0]  mem_op, fault_code;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata, fault_va;
  logic        mem_ack = 1'b0, mem_sc_ok = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [27:0] ref_ppn;
  logic [9:0]  ref_flags;

  always #2 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .root_base(ROOT),
    .miss_valid(miss_valid), .miss_va(miss_va), .miss_write(miss_write), .miss_remote(miss_remote),
    .busy(busy), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_sc_ok(mem_sc_ok),
    .done(done), .fault(fault), .fault_code(fault_code), .fault_va(fault_va),
    .ref_ppn(ref_ppn), .ref_flags(ref_flags), .ref_big(ref_big)
  );

  logic [31:0] mem [logic [39:0]];
  int          n_chk = 0, n_bad = 0;
  int          ll_cnt, sc_cnt, rd_cnt, log_n;
  logic [39:0] log_addr [16];
  logic [1:0]  log_op [16];
  int          fail_left;
  logic        interf_en;
  logic [31:0] interf_val;

  function automatic logic [31:0] mrd(input logic [39:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ll_cnt = 0; sc_cnt = 0; rd_cnt = 0; log_n = 0;
    fail_left = 0; interf_en = 1'b0; interf_val = '0;
  endtask

  task automatic model_loop();
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (log_n < 16) begin log_addr[log_n] = mem_addr; log_op[log_n] = mem_op; end
        log_n++;
        if (mem_op == 2'd2) begin
          sc_cnt++;
          if (fail_left > 0) begin
            fail_left--;
            mem_sc_ok <= 1'b0;
            if (interf_en) mem[mem_addr] = interf_val;
          end else begin
            mem[mem_addr] = mem_wdata;
            mem_sc_ok <= 1'b1;
          end
        end else begin
          if (mem_op == 2'd1) ll_cnt++; else rd_cnt++;
          mem_rdata <= mrd(mem_addr);
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  endtask

  task automatic start_walk(input logic [31:0] va, input logic wr, input logic rem);
    @(negedge clk);
    miss_va = va; miss_write = wr; miss_remote = rem; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  function automatic logic [39:0] l1a_of(input logic [31:0] va);
    return ROOT + 40'(va[31:21]) * 4;
  endfunction

  function automatic logic [39:0] l2a_of(input logic [31:0] l1w, input logic [31:0] va);
    return 40'(l1w[27:0]) * 4096 + 40'(va[20:12]) * 8;
  endfunction

  task automatic run_vectors();
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [39:0] a1, a2, ent;
      logic [27:0] eppn;
      v = VECS[i];
      mem.delete();
      clear_log();
      a1 = l1a_of(v.va);
      a2 = l2a_of(v.l1, v.va);
      mem[a1] = v.l1;
      if (v.l1[30]) begin mem[a2] = v.l2a; mem[a2 + 4] = v.l2b; end
      start_walk(v.va, v.wr, v.rem);
      wait_done();
      chk("R5 fault flag", 64'(fault), 64'(v.efc != 0));
      chk("R5 fault code", 64'(fault_code), 64'(v.efc));
      chk("R10 busy at done", 64'(busy), 64'd1);
      chk("R2 first address", 64'(log_addr[0]), 64'(a1));
      chk("R2 first op LL", 64'(log_op[0]), 64'd1);
      chk("R8 SC count", 64'(sc_cnt), 64'(v.esc));
      if (v.efc != 0) begin
        chk("R5 fault va", 64'(fault_va), 64'(v.va));
      end else begin
        ent  = v.l1[30] ? a2 : a1;
        eppn = v.l1[30] ? v.l2b[27:0] : {v.l1[18:0], v.va[20:12]};
        chk(v.l1[30] ? "R3 ppn" : "R4 ppn", 64'(ref_ppn), 64'(eppn));
        chk(v.l1[30] ? "R3 big" : "R4 big", 64'(ref_big), 64'(!v.l1[30]));
        chk("R11 flags", 64'(ref_flags), 64'(v.eflg));
        chk(v.wr ? "R7 memory flags" : "R6 memory flags", 64'(mrd(ent) >> 22), 64'(v.eflg));
        if (v.l1[30]) begin
          chk("R3 second-level LL address", 64'(log_addr[1]), 64'(a2));
          chk("R3 page word read", 64'(log_addr[log_n-1]), 64'(a2 + 4));
          chk("R3 page word op", 64'(log_op[log_n-1]), 64'd0);
        end
      end
      @(negedge clk);
      chk("R10 idle after done", 64'(busy), 64'd0);
    end
  endtask

  task automatic run_directed();
    logic [39:0] a1, a2;
    // R9: refused SC, another agent already set L and D -> no second SC
    mem.delete(); clear_log();
    a1 = l1a_of(32'h0120_0000);
    mem[a1] = 32'h8400_0007;
    fail_left = 1; interf_en = 1'b1; interf_val = 32'hA440_0007;
    start_walk(32'h0120_0000, 1'b1, 1'b0);
    wait_done();
    chk("R9 SC tries", 64'(sc_cnt), 64'd1);
    chk("R9 LL reissued", 64'(ll_cnt), 64'd2);
    chk("R9 retry address", 64'(log_addr[2]), 64'(a1));
    chk("R9 flags from fresh word", 64'(ref_flags), 64'h291);
    chk("R9 ppn", 64'(ref_ppn), 64'({19'h7, 9'h0}));
    @(negedge clk);

    // R9: two refusals without interference -> third SC succeeds
    mem.delete(); clear_log();
    mem[a1] = 32'h8400_0007;
    fail_left = 2;
    start_walk(32'h0120_0000, 1'b1, 1'b0);
    wait_done();
    chk("R9 SC tries double", 64'(sc_cnt), 64'd3);
    chk("R9 LL count double", 64'(ll_cnt), 64'd3);
    chk("R8 stored word", 64'(mrd(a1)), 64'hA440_0007);
    @(negedge clk);

    // R10: second miss while busy is ignored
    mem.delete(); clear_log();
    a1 = l1a_of(32'h8040_5000);
    a2 = l2a_of(32'hC000_0123, 32'h8040_5000);
    mem[a1] = 32'hC000_0123; mem[a2] = 32'hA000_0000; mem[a2 + 4] = 32'h0000_0042;
    start_walk(32'h8040_5000, 1'b0, 1'b0);
    chk("R10 busy during walk", 64'(busy), 64'd1);
    miss_va = 32'h0060_3000; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    wait_done();
    chk("R10 ppn unaffected", 64'(ref_ppn), 64'h42);
    chk("R10 fault va unaffected", 64'(fault_va), 64'h8040_5000);
    repeat (6) @(negedge clk);
    chk("R10 no extra walk", 64'(log_n), 64'd3);
    chk("R1 idle no request", 64'(mem_req), 64'd0);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    fork
      model_loop();
      begin run_vectors(); run_directed(); end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule